// File: doc/BRIEF.md
# Hybrid Coherence Directory Entry Tracker

This block holds the sharer state of one cache line in a memory-side directory. It has two ways to represent the sharers. While few caches hold the line, it keeps the identity of each holder in a small fixed set of slots. When one more distinct holder arrives than the slots can take, it drops the identities and keeps only a count. Which coherence action a write triggers follows from this representation. In identity mode, it sends one update to each recorded holder other than the writer. In count mode, it sends a single broadcast-invalidate request to every L1 cache.

The write is acknowledged only after the whole action has finished. For updates, that means an acknowledgement has come back for every update sent. For a broadcast, it means the broadcast-completion input has fired; at that point the entry also resets to identity mode with no copies. Copy registrations and writes are accepted only while the entry is idle. The slot count is a compile-time parameter between 1 and 8.

Top module: `dir_entry_tracker`

## Requirements
- R1: After reset, `copies` is 0 and `count_only` is 0. `add_ready` and `wr_ready` are 1. `upd_valid`, `bcast_valid` and `wr_ack` are 0.
- R2: In identity mode (`count_only`=0), an accepted add of an ID that is not yet recorded stores it in the lowest free slot and raises `copies` by one, provided fewer than SLOTS IDs are recorded.
- R3: In identity mode, an accepted add of an ID that is already recorded leaves `copies`, `count_only` and the recorded set unchanged.
- R4: In identity mode, an add of a new ID when SLOTS IDs are already recorded sets `count_only` to 1 and `copies` to SLOTS+1, and discards all identities. In count mode, every accepted add raises `copies` by one, duplicates included, saturating at 2^ID_W.
- R5: A write accepted in identity mode issues one update per recorded holder, excluding the writer ID. The updates go out one per `upd_valid`/`upd_ready` handshake, in ascending slot order; slot order is the order in which the IDs were first added. `upd_target` stays stable while the handshake is stalled.
- R6: A write accepted in identity mode with no target (no copies, or the writer is the only holder) raises `wr_ack` in the cycle right after acceptance, without issuing any update.
- R7: A write accepted in count mode raises `bcast_valid`, holds it until `bcast_ready`, and issues no update.
- R8: `wr_ack` is a one-cycle pulse. For updates, it rises in the cycle after the `upd_ack` that brings the number of acknowledgements up to the number of updates issued. For a broadcast, it rises in the cycle after `bcast_done`; it never rises before.
- R9: After a broadcast completes, `count_only` is 0 and `copies` is 0. An update-mode write leaves the recorded set and `copies` unchanged.
- R10: `add_ready` and `wr_ready` are 0 while a write is in progress, so adds offered then are not taken. A write offered in the same idle cycle as an add takes priority, and that add is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| add_valid | input | 1 | A cache has taken a copy of the line |
| add_id | input | ID_W | ID of the cache taking the copy |
| add_ready | output | 1 | Add is accepted this cycle |
| wr_valid | input | 1 | Write request to the line |
| wr_id | input | ID_W | ID of the writing cache |
| wr_ready | output | 1 | Write is accepted this cycle |
| upd_valid | output | 1 | Update request to one holder |
| upd_target | output | ID_W | ID of the holder to update |
| upd_ready | input | 1 | Update request taken |
| upd_ack | input | 1 | One update acknowledgement returned |
| bcast_valid | output | 1 | Broadcast-invalidate request |
| bcast_ready | input | 1 | Broadcast request taken |
| bcast_done | input | 1 | Broadcast invalidation completed |
| wr_ack | output | 1 | Write acknowledged, one-cycle pulse |
| copies | output | $clog2(2^ID_W+1) | Current copy count |
| count_only | output | 1 | 1 when only the count is kept |

## Verification
The bench targets these corner cases:

- **Duplicate adds.** A design that counted them would report too many copies, and the update list would then disagree with the count.
- **The add that crosses the slot limit.** An off-by-one would switch to count mode one holder early or one too late.
- **A writer that is itself a holder.** A wrong design would send an update back to the writer, or would wait forever for an acknowledgement that never comes.
- **Stalled handshakes and a premature acknowledgement.** The bench stalls both the update and broadcast handshakes and holds back acknowledgements. This catches a design that skips or reorders targets, or that acknowledges the write before the last update acknowledgement or before broadcast completion.
- **Count saturation, the write-over-add collision, and the reset to an empty identity-mode entry after a broadcast.**

// File: rtl/dir_pkg.sv
// Shared types for the directory entry tracker.
package dir_pkg;
    // Write sequencing states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_UPD_SEND,
        ST_UPD_WAIT,
        ST_BC_SEND,
        ST_BC_WAIT,
        ST_ACK
    } wr_state_t;
endpackage

// File: rtl/dir_lowest_pick.sv
// Lowest-index picker: grants the lowest set bit of req as a one-hot vector.
// Assumes nothing about req; any is high when some bit is set.
module dir_lowest_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt,
    output logic         any
);
    // Scan from bit 0 upward, granting the first set bit only.
    always_comb begin
        logic seen;
        seen = 1'b0;
        for (int i = 0; i < N; i++) begin
            gnt[i] = req[i] && !seen;
            seen   = seen || req[i];
        end
    end

    assign any = |req;
endmodule

// File: rtl/dir_sharer_store.sv
// Sharer storage: SLOTS identity slots with valid bits, a copy count and the
// mode flag. Adds fill the lowest free slot. An add past SLOTS distinct IDs
// switches to count-only mode. clr empties the entry.
// Assumes add_fire and clr never coincide (the sequencer guarantees this).
module dir_sharer_store #(
    parameter int ID_W    = 4,
    parameter int SLOTS   = 4,
    parameter int CNT_MAX = 16,
    parameter int CNT_W   = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       add_fire,
    input  logic [ID_W-1:0]            add_id,
    input  logic                       clr,
    output logic [SLOTS-1:0][ID_W-1:0] slot_id,
    output logic [SLOTS-1:0]           slot_vld,
    output logic [CNT_W-1:0]           copies,
    output logic                       cnt_only
);
    logic [SLOTS-1:0] hit_vec;
    logic [SLOTS-1:0] free_oh;
    logic             free_any;

    // Flag the slots that already hold the incoming ID.
    always_comb begin
        for (int i = 0; i < SLOTS; i++)
            hit_vec[i] = slot_vld[i] && (slot_id[i] == add_id);
    end

    dir_lowest_pick #(.N(SLOTS)) u_free (
        .req (~slot_vld),
        .gnt (free_oh),
        .any (free_any)
    );

    // Update the slots, count and mode on add or clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_id  <= '0;
            slot_vld <= '0;
            copies   <= '0;
            cnt_only <= 1'b0;
        end else if (clr) begin
            slot_vld <= '0;
            copies   <= '0;
            cnt_only <= 1'b0;
        end else if (add_fire) begin
            if (cnt_only) begin
                if (copies != CNT_W'(CNT_MAX))
                    copies <= copies + CNT_W'(1);
            end else if (!(|hit_vec)) begin
                if (free_any) begin
                    for (int i = 0; i < SLOTS; i++)
                        if (free_oh[i]) slot_id[i] <= add_id;
                    slot_vld <= slot_vld | free_oh;
                    copies   <= copies + CNT_W'(1);
                end else begin
                    slot_vld <= '0;
                    copies   <= CNT_W'(SLOTS + 1);
                    cnt_only <= 1'b1;
                end
            end
        end
    end

    a_r4_no_locations_in_count_mode: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_only |-> (slot_vld == '0));
    a_r2_count_matches_slots: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_only |-> ($countones(slot_vld) == int'(copies)));
    a_r3_duplicate_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (add_fire && !cnt_only && (|hit_vec) && !clr) |=> ($stable(slot_vld) && $stable(copies)));
    a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ((copies == '0) && !cnt_only));
    a_r4_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        int'(copies) <= CNT_MAX);
endmodule

// File: rtl/dir_write_fsm.sv
// Write sequencer. It accepts one write at a time. In identity mode it walks
// the recorded holders (minus the writer) in ascending slot order, one per
// handshake, then waits for the matching number of update acknowledgements.
// In count mode it issues one broadcast and waits for completion, then clears
// the entry. Assumes upd_ack never exceeds the number of updates issued.
module dir_write_fsm #(
    parameter int ID_W  = 4,
    parameter int SLOTS = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_fire,
    input  logic [ID_W-1:0]            wr_id,
    input  logic [SLOTS-1:0][ID_W-1:0] slot_id,
    input  logic [SLOTS-1:0]           slot_vld,
    input  logic                       cnt_only,
    input  logic                       upd_ready,
    input  logic                       upd_ack,
    input  logic                       bcast_ready,
    input  logic                       bcast_done,
    output logic                       idle,
    output logic                       upd_valid,
    output logic [ID_W-1:0]            upd_target,
    output logic                       bcast_valid,
    output logic                       wr_ack,
    output logic                       clr
);
    import dir_pkg::*;
    localparam int RW = $clog2(SLOTS + 1);

    wr_state_t        state;
    logic [SLOTS-1:0] pend;
    logic [SLOTS-1:0] tgt_mask;
    logic [SLOTS-1:0] pick_oh;
    logic             pick_any;
    logic [RW-1:0]    tgt_cnt;
    logic [RW-1:0]    rem;
    logic [RW-1:0]    rem_nxt;
    logic [ID_W-1:0]  wr_q;

    // Build the target set (holders other than the writer) and its size.
    always_comb begin
        tgt_cnt = '0;
        for (int i = 0; i < SLOTS; i++) begin
            tgt_mask[i] = slot_vld[i] && (slot_id[i] != wr_id);
            tgt_cnt     = tgt_cnt + RW'(tgt_mask[i]);
        end
    end

    dir_lowest_pick #(.N(SLOTS)) u_next (
        .req (pend),
        .gnt (pick_oh),
        .any (pick_any)
    );

    // Select the ID of the slot being offered.
    always_comb begin
        upd_target = '0;
        for (int i = 0; i < SLOTS; i++)
            if (pick_oh[i]) upd_target = upd_target | slot_id[i];
    end

    // Outstanding acknowledgements after this cycle's acknowledgement.
    assign rem_nxt = (upd_ack && rem != '0) ? rem - RW'(1) : rem;

    // Step through the write sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            pend  <= '0;
            rem   <= '0;
            wr_q  <= '0;
        end else begin
            case (state)
                ST_IDLE: if (wr_fire) begin
                    wr_q <= wr_id;
                    if (cnt_only) begin
                        state <= ST_BC_SEND;
                    end else if (tgt_mask == '0) begin
                        state <= ST_ACK;
                    end else begin
                        pend  <= tgt_mask;
                        rem   <= tgt_cnt;
                        state <= ST_UPD_SEND;
                    end
                end
                ST_UPD_SEND: begin
                    rem <= rem_nxt;
                    if (upd_ready) begin
                        pend <= pend & ~pick_oh;
                        if ((pend & ~pick_oh) == '0) state <= ST_UPD_WAIT;
                    end
                end
                ST_UPD_WAIT: begin
                    rem <= rem_nxt;
                    if (rem_nxt == '0) state <= ST_ACK;
                end
                ST_BC_SEND: if (bcast_ready) state <= ST_BC_WAIT;
                ST_BC_WAIT: if (bcast_done) state <= ST_ACK;
                ST_ACK:     state <= ST_IDLE;
                default:    state <= ST_IDLE;
            endcase
        end
    end

    assign idle        = (state == ST_IDLE);
    assign upd_valid   = (state == ST_UPD_SEND) && pick_any;
    assign bcast_valid = (state == ST_BC_SEND);
    assign wr_ack      = (state == ST_ACK);
    assign clr         = (state == ST_BC_WAIT) && bcast_done;

    a_r5_target_held: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_ready) |=> (upd_valid && $stable(upd_target)));
    a_r5_writer_excluded: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> (upd_target != wr_q));
    a_r7_bcast_held: assert property (@(posedge clk) disable iff (!rst_n)
        (bcast_valid && !bcast_ready) |=> bcast_valid);
    a_r8_one_action: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({upd_valid, bcast_valid, wr_ack}));
    a_r8_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ack |=> !wr_ack);
endmodule

// File: rtl/dir_entry_tracker.sv
// Top of the directory entry tracker. It joins the sharer store and the write
// sequencer and arbitrates the add and write ports. A write wins over an add
// offered in the same idle cycle. Assumes 1 <= SLOTS <= 8 and SLOTS < 2**ID_W.
module dir_entry_tracker #(
    parameter int ID_W  = 4,
    parameter int SLOTS = 4,
    localparam int CNT_MAX = 1 << ID_W,
    localparam int CNT_W   = $clog2(CNT_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             add_valid,
    input  logic [ID_W-1:0]  add_id,
    output logic             add_ready,
    input  logic             wr_valid,
    input  logic [ID_W-1:0]  wr_id,
    output logic             wr_ready,
    output logic             upd_valid,
    output logic [ID_W-1:0]  upd_target,
    input  logic             upd_ready,
    input  logic             upd_ack,
    output logic             bcast_valid,
    input  logic             bcast_ready,
    input  logic             bcast_done,
    output logic             wr_ack,
    output logic [CNT_W-1:0] copies,
    output logic             count_only
);
    logic                       idle;
    logic                       clr;
    logic [SLOTS-1:0][ID_W-1:0] slot_id;
    logic [SLOTS-1:0]           slot_vld;

    // Accept requests only while idle; a write blocks a same-cycle add.
    assign wr_ready  = idle;
    assign add_ready = idle && !wr_valid;

    dir_sharer_store #(
        .ID_W(ID_W), .SLOTS(SLOTS), .CNT_MAX(CNT_MAX), .CNT_W(CNT_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .add_fire (add_valid && add_ready),
        .add_id   (add_id),
        .clr      (clr),
        .slot_id  (slot_id),
        .slot_vld (slot_vld),
        .copies   (copies),
        .cnt_only (count_only)
    );

    dir_write_fsm #(.ID_W(ID_W), .SLOTS(SLOTS)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_fire     (wr_valid && wr_ready),
        .wr_id       (wr_id),
        .slot_id     (slot_id),
        .slot_vld    (slot_vld),
        .cnt_only    (count_only),
        .upd_ready   (upd_ready),
        .upd_ack     (upd_ack),
        .bcast_ready (bcast_ready),
        .bcast_done  (bcast_done),
        .idle        (idle),
        .upd_valid   (upd_valid),
        .upd_target  (upd_target),
        .bcast_valid (bcast_valid),
        .wr_ack      (wr_ack),
        .clr         (clr)
    );

    a_r10_write_beats_add: assert property (@(posedge clk) disable iff (!rst_n)
        (add_valid && wr_valid && wr_ready) |=> $stable(copies));
    a_r10_busy_blocks_add: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_ready && !clr) |=> $stable(copies));
endmodule

// File: tb/tb_dir_entry_tracker.sv
module tb_dir_entry_tracker;
    localparam int CLK_PERIOD = 10;
    localparam int ID_W  = 4;
    localparam int SLOTS = 4;
    localparam int CNT_W = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic add_valid = 0, wr_valid = 0, upd_ready = 0, upd_ack = 0;
    logic bcast_ready = 0, bcast_done = 0;
    logic [ID_W-1:0] add_id = '0, wr_id = '0;
    logic add_ready, wr_ready, upd_valid, bcast_valid, wr_ack, count_only;
    logic [ID_W-1:0] upd_target;
    logic [CNT_W-1:0] copies;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dir_entry_tracker #(.ID_W(ID_W), .SLOTS(SLOTS)) dut (
        .clk(clk), .rst_n(rst_n),
        .add_valid(add_valid), .add_id(add_id), .add_ready(add_ready),
        .wr_valid(wr_valid), .wr_id(wr_id), .wr_ready(wr_ready),
        .upd_valid(upd_valid), .upd_target(upd_target), .upd_ready(upd_ready),
        .upd_ack(upd_ack), .bcast_valid(bcast_valid), .bcast_ready(bcast_ready),
        .bcast_done(bcast_done), .wr_ack(wr_ack), .copies(copies),
        .count_only(count_only)
    );

    // Stimulus table: {added ID, expected copies after the add}.
    localparam int NV = 7;
    localparam int VEC [NV][2] = '{
        '{3, 1}, '{7, 2}, '{3, 2}, '{5, 3}, '{7, 3}, '{9, 4}, '{9, 4}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_add(input int id);
        @(negedge clk);
        add_valid = 1'b1;
        add_id = ID_W'(id);
        @(posedge clk);
        #1 add_valid = 1'b0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    // Update-mode write; with_add offers a colliding add in the accept cycle.
    task automatic upd_write(input int w, input int n, input int t0, input int t1,
                             input int t2, input int t3, input bit with_add);
        int tl[4];
        tl = '{t0, t1, t2, t3};
        @(negedge clk);
        wr_valid = 1'b1;
        wr_id = ID_W'(w);
        if (with_add) begin
            add_valid = 1'b1;
            add_id = 4'd13;
        end
        @(posedge clk);
        #1 wr_valid = 1'b0;
        add_valid = 1'b0;
        chk("R10 wr_ready while busy", int'(wr_ready), 0);
        chk("R10 add_ready while busy", int'(add_ready), 0);
        for (int k = 0; k < n; k++) begin
            chk("R5 upd_valid", int'(upd_valid), 1);
            chk("R5 upd_target order", int'(upd_target), tl[k]);
            if (k == 0) begin
                do_add(12);  // offered while busy: must be dropped (R10)
                chk("R5 target held in stall", int'(upd_target), tl[k]);
            end
            @(negedge clk);
            upd_ready = 1'b1;
            @(posedge clk);
            #1 upd_ready = 1'b0;
        end
        chk("R5 no extra update", int'(upd_valid), 0);
        for (int k = 0; k < n; k++) begin
            chk("R8 no early ack", int'(wr_ack), 0);
            @(negedge clk);
            upd_ack = 1'b1;
            @(posedge clk);
            #1 upd_ack = 1'b0;
        end
        chk("R8 ack after last upd_ack", int'(wr_ack), 1);
        tick();
        chk("R8 ack is a pulse", int'(wr_ack), 0);
        chk("R9 list kept after update", int'(copies), 4);
    endtask

    task automatic bcast_write(input int w);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_id = ID_W'(w);
        @(posedge clk);
        #1 wr_valid = 1'b0;
        chk("R7 bcast_valid", int'(bcast_valid), 1);
        chk("R7 no update in count mode", int'(upd_valid), 0);
        tick();
        chk("R7 bcast held until ready", int'(bcast_valid), 1);
        @(negedge clk);
        bcast_ready = 1'b1;
        @(posedge clk);
        #1 bcast_ready = 1'b0;
        chk("R7 bcast dropped after ready", int'(bcast_valid), 0);
        tick();
        chk("R8 no ack before bcast_done", int'(wr_ack), 0);
        @(negedge clk);
        bcast_done = 1'b1;
        @(posedge clk);
        #1 bcast_done = 1'b0;
        chk("R8 ack after bcast_done", int'(wr_ack), 1);
        chk("R9 copies cleared", int'(copies), 0);
        chk("R9 identity mode after bcast", int'(count_only), 0);
        tick();
        chk("R8 ack pulse after bcast", int'(wr_ack), 0);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        chk("R1 copies", int'(copies), 0);
        chk("R1 count_only", int'(count_only), 0);
        chk("R1 add_ready", int'(add_ready), 1);
        chk("R1 wr_ready", int'(wr_ready), 1);
        chk("R1 no outputs", int'({upd_valid, bcast_valid, wr_ack}), 0);

        for (int v = 0; v < NV; v++) begin
            int prev;
            prev = int'(copies);
            do_add(VEC[v][0]);
            chk((VEC[v][1] != prev) ? "R2 new id" : "R3 duplicate id",
                int'(copies), VEC[v][1]);
            chk("R2 identity mode", int'(count_only), 0);
        end

        // Slots: 0=3, 1=7, 2=5, 3=9.
        upd_write(7, 3, 3, 5, 9, 0, 0);
        upd_write(2, 4, 3, 7, 5, 9, 0);
        upd_write(3, 3, 7, 5, 9, 0, 1);  // R10: write beats add of 13
        chk("R10 colliding add dropped", int'(copies), 4);

        do_add(11);
        chk("R4 switch copies", int'(copies), 5);
        chk("R4 switch mode", int'(count_only), 1);
        do_add(11);
        chk("R4 count mode counts dup", int'(copies), 6);
        bcast_write(4);

        // No copies at all: immediate ack.
        @(negedge clk);
        wr_valid = 1'b1;
        wr_id = 4'd2;
        @(posedge clk);
        #1 wr_valid = 1'b0;
        chk("R6 ack with no copies", int'(wr_ack), 1);
        chk("R6 no update", int'(upd_valid), 0);
        tick();

        // Writer is the only holder: immediate ack.
        do_add(6);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_id = 4'd6;
        @(posedge clk);
        #1 wr_valid = 1'b0;
        chk("R6 ack when writer sole holder", int'(wr_ack), 1);
        chk("R6 no update to writer", int'(upd_valid), 0);
        tick();
        chk("R9 sole holder kept", int'(copies), 1);

        // Saturation in count mode.
        for (int k = 0; k < 20; k++) begin
            do_add(k % 16);
            if (k == 3) begin
                chk("R4 switch at limit", int'(copies), 5);
                chk("R4 mode at limit", int'(count_only), 1);
            end
        end
        chk("R4 saturated count", int'(copies), 16);
        bcast_write(1);

        summary();
    end
endmodule